// File: doc/BRIEF.md
# Channel-Gain Scan Sequencer with Sample FIFO

This block sequences a multiplexed 12-bit, 8-channel sampling front end. The host loads a list of channel/range entries through a pair of byte registers: one selects the list index and the other writes the entry. Every accepted conversion trigger reads the current list entry and sends its channel and range code to the converter with a one-cycle start pulse. The list index then advances and returns to entry 0 after the highest index written. A trigger can come from a host write, from an internal tick, or from an external conversion input. Pacer-driven conversions can also be held back until an external start event.

Each finished result is packed into a 16-bit word and pushed into a 1024-deep sample FIFO. The result sits in the upper twelve bits and the channel sits in the low nibble. The host drains the FIFO through the data register. A status register reports data-ready, queue configuration error, FIFO overrun and the start-gate enable. The interrupt request follows data-ready while interrupts are enabled. The list must follow a parity rule: when it has more than one entry, each entry's channel must have the same parity as its index and the entry count must be even. A list that breaks this rule is flagged, and conversions are refused until it is corrected.

Top module: `acq_scan_seq`

## Requirements
- R1: A write to offset 6 sets the list index. A write to offset 7 stores an entry there, with the channel in bits [2:0] and the range code in bits [7:4]. On the cycle conv_start pulses, conv_chan and conv_range carry the fields of the current list entry.
- R2: The list length is one more than the highest index written since reset (1 if none). After each completed conversion the list index advances by one, and it returns to 0 after index length-1.
- R3: The list is in error when its length is above 1 and either the length is odd or some entry's channel parity differs from its index parity. A length of 1 is never in error. Status bit 6 shows the error, and while it is set every trigger is ignored.
- R4: Each stored sample word is {result[11:0], 1'b0, channel[2:0]}.
- R5: A write to offset 0 starts one conversion when the sequencer is idle, whatever the pacer setting.
- R6: Control register (offset 5) bits [1:0] select the pacer. A value of 3 converts on pace_tick, 2 converts on ext_conv, and 0 or 1 ignore both inputs.
- R7: When status/control bit 0 (offset 2) is set, pacer triggers are ignored until ext_start is seen. Any control write re-arms this gate.
- R8: Status bit 7 is set when a sample is stored and cleared by any write to offset 4. irq equals status bit 7 AND control bit 7.
- R9: A result that completes while the FIFO holds 1024 samples is discarded and sets status bit 5. Bit 5 stays set until a control write with pacer field 0.
- R10: Reads of offset 0 return samples in conversion order and pop one each. A read of an empty FIFO returns 0.
- R11: After reset, status, control, data and irq all read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Byte write strobe |
| wdata | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (pops FIFO at offset 0) |
| rdata | output | 16 | Read data for addr |
| irq | output | 1 | Interrupt request |
| pace_tick | input | 1 | Internal pacer tick |
| ext_conv | input | 1 | External conversion trigger |
| ext_start | input | 1 | External start event |
| conv_start | output | 1 | Start pulse to converter |
| conv_chan | output | 3 | Channel select |
| conv_range | output | 4 | Range code |
| conv_done | input | 1 | Converter result valid |
| conv_res | input | 12 | Converter result |

## Verification
The sequencer is driven through four kinds of list: a one-entry list with an odd channel, a four-entry list that wraps over several passes, a list grown to an odd length, and a list with a single parity-violating entry. Together these separate a correct wrap point and error rule from off-by-one length handling. Trigger sources are swept across all four pacer codes, each with both external inputs pulsed. This shows that exactly one source is active per code. The start gate is tried both before and after its external event. Finally the FIFO is filled to exactly its depth plus one conversion, which distinguishes the discard-and-flag behaviour from overwriting and confirms that every stored word keeps its order.

// File: rtl/acq_pkg.sv
package acq_pkg;
    localparam int CH_W    = 3;
    localparam int RG_W    = 4;
    localparam int RES_W   = 12;
    localparam int Q_DEPTH = 256;
    localparam int F_DEPTH = 1024;
    localparam int ADDR_W  = 4;

    // list entry: range in [7:4], spare bit 3, channel in [2:0]
    typedef struct packed {
        logic [RG_W-1:0] range;
        logic            spare;
        logic [CH_W-1:0] chan;
    } qent_t;

    typedef enum logic [1:0] {
        PACE_OFF  = 2'd0,
        PACE_RSVD = 2'd1,
        PACE_EXT  = 2'd2,
        PACE_INT  = 2'd3
    } pace_e;

    typedef enum logic {SEQ_IDLE, SEQ_BUSY} seq_e;

    localparam logic [ADDR_W-1:0] OFS_DATA  = 4'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 4'd2;
    localparam logic [ADDR_W-1:0] OFS_CLR   = 4'd4;
    localparam logic [ADDR_W-1:0] OFS_CTRL  = 4'd5;
    localparam logic [ADDR_W-1:0] OFS_QADDR = 4'd6;
    localparam logic [ADDR_W-1:0] OFS_QDATA = 4'd7;

    function automatic logic [RES_W+3:0] pack_sample(logic [RES_W-1:0] res, logic [CH_W-1:0] ch);
        return {res, 1'b0, ch};
    endfunction
endpackage

// File: rtl/acq_chan_queue.sv
module acq_chan_queue
    import acq_pkg::*;
#(
    parameter int DEPTH = Q_DEPTH
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [$clog2(DEPTH)-1:0]   wr_idx,
    input  qent_t                      wr_ent,
    input  logic [$clog2(DEPTH)-1:0]   rd_idx,
    output qent_t                      rd_ent,
    output logic [$clog2(DEPTH):0]     len,
    output logic                       cfg_err
);
    localparam int IW = $clog2(DEPTH);

    qent_t            mem [DEPTH];
    logic [DEPTH-1:0] mism;
    logic [IW-1:0]    top_idx;
    logic             any_wr;

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_idx] <= wr_ent;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mism    <= '0;
            top_idx <= '0;
            any_wr  <= 1'b0;
        end else if (wr_en) begin
            mism[wr_idx] <= wr_idx[0] ^ wr_ent.chan[0];
            any_wr       <= 1'b1;
            if (!any_wr || wr_idx > top_idx) top_idx <= wr_idx;
        end
    end

    assign rd_ent = mem[rd_idx];
    assign len    = any_wr ? ({1'b0, top_idx} + 1'b1) : (IW+1)'(1);

    logic [DEPTH-1:0] live;
    always_comb begin
        for (int i = 0; i < DEPTH; i++) live[i] = ((IW+1)'(i) < len);
    end

    assign cfg_err = (len > (IW+1)'(1)) && (len[0] || |(mism & live));
endmodule

// File: rtl/acq_fifo.sv
module acq_fifo #(
    parameter int DEPTH = 1024,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);

    logic [W-1:0] mem [DEPTH];
    logic [AW:0]  wp, rp;

    always_ff @(posedge clk) begin
        if (push) mem[wp[AW-1:0]] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp <= '0;
            rp <= '0;
        end else begin
            if (push) wp <= wp + 1'b1;
            if (pop)  rp <= rp + 1'b1;
        end
    end

    assign dout  = mem[rp[AW-1:0]];
    assign empty = (wp == rp);
    assign full  = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);

    p_no_push_full_r9: assert property (@(posedge clk) disable iff (rst) push |-> !full)
        else $error("push into full FIFO");
    p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (rst) pop |-> !empty)
        else $error("pop from empty FIFO");
endmodule

// File: rtl/acq_scan_seq.sv
module acq_scan_seq
    import acq_pkg::*;
#(
    parameter int QD   = Q_DEPTH,
    parameter int FD   = F_DEPTH,
    parameter int RW   = RES_W,
    parameter int AW   = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [AW-1:0]   addr,
    input  logic            wr_en,
    input  logic [7:0]      wdata,
    input  logic            rd_en,
    output logic [RW+3:0]   rdata,
    output logic            irq,
    input  logic            pace_tick,
    input  logic            ext_conv,
    input  logic            ext_start,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic [RG_W-1:0] conv_range,
    input  logic            conv_done,
    input  logic [RW-1:0]   conv_res
);
    localparam int QI_W   = $clog2(QD);
    localparam int WORD_W = RW + 4;

    logic [QI_W-1:0] qa, ptr;
    logic [QI_W:0]   q_len;
    logic            cfg_err;
    qent_t           cur;
    pace_e           pace;
    seq_e            st;
    logic            ien, ext_arm, started, ready, ovr;

    logic wr_qdata, wr_ctrl, sw_fire, pace_fire, fire, done_cap, push, pop;
    logic f_empty, f_full;
    logic [WORD_W-1:0] f_dout;

    assign wr_qdata  = wr_en && (addr == OFS_QDATA);
    assign wr_ctrl   = wr_en && (addr == OFS_CTRL);
    assign sw_fire   = wr_en && (addr == OFS_DATA);
    assign pace_fire = ((pace == PACE_INT) && pace_tick) || ((pace == PACE_EXT) && ext_conv);
    assign fire      = (sw_fire || (pace_fire && (!ext_arm || started)))
                       && !cfg_err && (st == SEQ_IDLE);
    assign done_cap  = (st == SEQ_BUSY) && conv_done;
    assign push      = done_cap && !f_full;
    assign pop       = rd_en && (addr == OFS_DATA) && !f_empty;

    acq_chan_queue #(.DEPTH(QD)) u_queue (
        .clk(clk), .rst(rst),
        .wr_en(wr_qdata), .wr_idx(qa), .wr_ent(qent_t'(wdata)),
        .rd_idx(ptr), .rd_ent(cur),
        .len(q_len), .cfg_err(cfg_err)
    );

    acq_fifo #(.DEPTH(FD), .W(WORD_W)) u_fifo (
        .clk(clk), .rst(rst),
        .push(push), .din(pack_sample(conv_res, conv_chan)),
        .pop(pop), .dout(f_dout), .empty(f_empty), .full(f_full)
    );

    // host-visible registers and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            qa      <= '0;
            ien     <= 1'b0;
            pace    <= PACE_OFF;
            ext_arm <= 1'b0;
            started <= 1'b0;
            ready   <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (wr_en && addr == OFS_QADDR) qa <= QI_W'(wdata);
            if (wr_en && addr == OFS_STAT)  ext_arm <= wdata[0];
            if (wr_ctrl) begin
                ien     <= wdata[7];
                pace    <= pace_e'(wdata[1:0]);
                started <= 1'b0;
                if (wdata[1:0] == 2'd0) ovr <= 1'b0;
            end
            if (ext_arm && ext_start)        started <= 1'b1;
            if (wr_en && addr == OFS_CLR)    ready <= 1'b0;
            if (push)                        ready <= 1'b1;
            if (done_cap && f_full)          ovr <= 1'b1;
        end
    end

    // conversion sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= SEQ_IDLE;
            ptr        <= '0;
            conv_start <= 1'b0;
            conv_chan  <= '0;
            conv_range <= '0;
        end else begin
            conv_start <= fire;
            if (fire) begin
                st         <= SEQ_BUSY;
                conv_chan  <= cur.chan;
                conv_range <= cur.range;
            end else if (done_cap) begin
                st  <= SEQ_IDLE;
                ptr <= (({1'b0, ptr} + 1'b1) >= q_len) ? '0 : ptr + 1'b1;
            end
        end
    end

    always_comb begin
        case (addr)
            OFS_DATA: rdata = f_empty ? '0 : f_dout;
            OFS_STAT: rdata = WORD_W'({ready, cfg_err, ovr, 4'b0, ext_arm});
            OFS_CTRL: rdata = WORD_W'({ien, 5'b0, pace});
            default:  rdata = '0;
        endcase
    end

    assign irq = ready && ien;

    p_ovr_needs_full_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr) |-> $past(f_full)) else $error("overrun without full FIFO");
    p_err_blocks_r3: assert property (@(posedge clk) disable iff (rst)
        conv_start |-> !$past(cfg_err)) else $error("conversion with list error");
    p_ptr_in_len_r2: assert property (@(posedge clk) disable iff (rst)
        {1'b0, ptr} < q_len) else $error("list index past length");
    p_start_once_r5: assert property (@(posedge clk) disable iff (rst)
        conv_start |=> !conv_start) else $error("back-to-back start");
endmodule

// File: tb/acq_scan_seq_tb.sv
module acq_scan_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FD = 1024;

    logic clk = 0, rst = 1;
    logic [3:0]  addr = 0;
    logic        wr_en = 0, rd_en = 0;
    logic [7:0]  wdata = 0;
    logic [15:0] rdata;
    logic        irq, pace_tick = 0, ext_conv = 0, ext_start = 0;
    logic        conv_start, conv_done = 0;
    logic [2:0]  conv_chan;
    logic [3:0]  conv_range;
    logic [11:0] conv_res = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acq_scan_seq u_dut (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .rd_en(rd_en), .rdata(rdata), .irq(irq),
        .pace_tick(pace_tick), .ext_conv(ext_conv), .ext_start(ext_start),
        .conv_start(conv_start), .conv_chan(conv_chan), .conv_range(conv_range),
        .conv_done(conv_done), .conv_res(conv_res)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // bench-side model of the list and the sample stream
    logic [2:0]  exp_ch [256];
    logic [3:0]  exp_rg [256];
    int          b_len = 1, b_ptr = 0, b_top = -1, nconv = 0;
    logic [15:0] sb [$];
    logic        pend = 0;
    logic [2:0]  lat_ch;
    logic [3:0]  lat_rg;

    always @(posedge clk) begin
        conv_done <= 1'b0;
        if (conv_start) begin
            pend   <= 1'b1;
            lat_ch <= conv_chan;
            lat_rg <= conv_range;
            chk("R1 chan", int'(conv_chan), int'(exp_ch[b_ptr]));
            chk("R1 range", int'(conv_range), int'(exp_rg[b_ptr]));
        end
        if (pend) begin
            pend      <= 1'b0;
            conv_done <= 1'b1;
            conv_res  <= {lat_rg, 1'b0, lat_ch, 4'(nconv)};
            if (sb.size() < FD)
                sb.push_back({exp_rg[b_ptr], 1'b0, exp_ch[b_ptr], 4'(nconv), 1'b0, exp_ch[b_ptr]});
            nconv <= nconv + 1;
            b_ptr <= (b_ptr + 1 >= b_len) ? 0 : b_ptr + 1;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] v);
        @(negedge clk); addr = a; rd_en = 1; #1 v = rdata;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic qwr(input int idx, input logic [2:0] ch, input logic [3:0] rg);
        wr(4'd6, 8'(idx));
        wr(4'd7, {rg, 1'b0, ch});
        exp_ch[idx] = ch; exp_rg[idx] = rg;
        if (idx > b_top) b_top = idx;
        b_len = b_top + 1;
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        if (which == 0) pace_tick = 1; else if (which == 1) ext_conv = 1; else ext_start = 1;
        @(negedge clk);
        pace_tick = 0; ext_conv = 0; ext_start = 0;
        waitc(5);
    endtask

    task automatic drain(input string req);
        logic [15:0] v;
        while (sb.size() > 0) begin
            rd(4'd0, v);
            chk(req, int'(v), int'(sb.pop_front()));
        end
    endtask

    function automatic logic exp_err();
        if (b_len <= 1) return 0;
        if (b_len % 2) return 1;
        for (int i = 0; i < b_len; i++) if ((i % 2) != int'(exp_ch[i][0])) return 1;
        return 0;
    endfunction

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [15:0] v;
        int c0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R11 reset state
        rd(4'd2, v); chk("R11 status", int'(v), 0);
        rd(4'd5, v); chk("R11 control", int'(v), 0);
        rd(4'd0, v); chk("R11 data", int'(v), 0);
        chk("R11 irq", int'(irq), 0);

        // R3 one-entry list with odd channel is legal; R5 software start
        qwr(0, 3'd3, 4'd5);
        rd(4'd2, v); chk("R3 len1 ok", int'(v[6]), 0);
        wr(4'd0, 8'h00); waitc(5);
        chk("R5 sw conv", nconv, 1);
        rd(4'd2, v); chk("R8 ready set", int'(v[7]), 1);
        chk("R8 irq masked", int'(irq), 0);
        drain("R4 sample word");

        // R2 four-entry list, several passes
        for (int i = 0; i < 4; i++) qwr(i, 3'(i), 4'(i + 1));
        rd(4'd2, v); chk("R3 valid list", int'(v[6]), 0);
        for (int k = 0; k < 10; k++) begin wr(4'd0, 8'h00); waitc(5); end
        chk("R2 conv count", nconv, 11);
        wr(4'd5, 8'h80); chk("R8 irq on", int'(irq), 1);
        wr(4'd4, 8'h00);
        rd(4'd2, v); chk("R8 ready cleared", int'(v[7]), 0);
        chk("R8 irq cleared", int'(irq), 0);
        drain("R2 R10 order");
        rd(4'd0, v); chk("R10 empty read", int'(v), 0);

        // R3 odd length, fixed, then parity breach
        qwr(4, 3'd4, 4'd0);
        rd(4'd2, v); chk("R3 odd len", int'(v[6]), int'(exp_err()));
        c0 = nconv; wr(4'd0, 8'h00); waitc(5);
        chk("R3 trigger ignored", nconv, c0);
        rd(4'd0, v); chk("R3 no sample", int'(v), 0);
        qwr(5, 3'd5, 4'd2);
        rd(4'd2, v); chk("R3 even len", int'(v[6]), int'(exp_err()));
        qwr(2, 3'd3, 4'd3);
        rd(4'd2, v); chk("R3 parity breach", int'(v[6]), int'(exp_err()));
        qwr(2, 3'd6, 4'd3);
        rd(4'd2, v); chk("R3 parity fixed", int'(v[6]), int'(exp_err()));

        // R6 pacer codes
        for (int code = 0; code < 4; code++) begin
            wr(4'd5, 8'(code));
            c0 = nconv; pulse(0);
            chk("R6 pace_tick", nconv - c0, (code == 3) ? 1 : 0);
            c0 = nconv; pulse(1);
            chk("R6 ext_conv", nconv - c0, (code == 2) ? 1 : 0);
        end
        drain("R6 samples");

        // R7 start gate
        wr(4'd2, 8'h01); wr(4'd5, 8'h03);
        c0 = nconv; pulse(0); chk("R7 gated", nconv - c0, 0);
        pulse(2);
        c0 = nconv; pulse(0); chk("R7 released", nconv - c0, 1);
        wr(4'd5, 8'h03);
        c0 = nconv; pulse(0); chk("R7 rearmed", nconv - c0, 0);
        wr(4'd2, 8'h00);
        drain("R7 samples");

        // R9 overrun
        wr(4'd5, 8'h00);
        for (int k = 0; k < FD + 1; k++) begin wr(4'd0, 8'h00); waitc(4); end
        rd(4'd2, v); chk("R9 overrun set", int'(v[5]), 1);
        wr(4'd5, 8'h83);
        rd(4'd2, v); chk("R9 overrun sticky", int'(v[5]), 1);
        chk("R9 kept count", sb.size(), FD);
        drain("R9 R10 full contents");
        rd(4'd0, v); chk("R9 discarded", int'(v), 0);
        wr(4'd5, 8'h00);
        rd(4'd2, v); chk("R9 overrun clear", int'(v[5]), 0);

        summary();
    end
endmodule